// File: doc/BRIEF.md
# Binary tower field multiplier

This block multiplies two elements of a binary tower field GF(2^(2^k)) and returns their product. It is purely combinational: there is no clock, no storage and no handshake. The element width `WIDTH` is a parameter and must be a power of two from 1 to 128. Any other value stops elaboration.

Each element of width n is split into a low half (bits 0 to n/2-1) and a high half (bits n/2 to n-1). The high half is the coefficient of the top tower generator X. That generator obeys X·X = X·X' + 1, where X' is the next-lower generator, the half-width element with only bit n/4 set.

The product is built by recursion, splitting each operand into halves with a three-submultiply Karatsuba scheme. The recursion ends in single-bit AND gates. The reduction term, multiplication by X', is built as a dedicated constant-generator stage and not as a general multiplier.

Top module: `tower_mul`

## Requirements
- R1: At WIDTH 1 the product is the AND of the two operand bits.
- R2: At WIDTH 2, with X0·X0 = X0 + 1, product bit 0 is a0·b0 ^ a1·b1 and product bit 1 is a0·b1 ^ a1·b0 ^ a1·b1.
- R3: For widths 8, 16 and 64, the product of arbitrary operands equals the tower field product given by the relation X·X = X·X' + 1 at every level.
- R4: The value 1 (only bit 0 set) is the multiplicative identity in either operand position.
- R5: The product is commutative: swapping the operands leaves the result unchanged.
- R6: Multiplication distributes over XOR: a·(b ^ c) = a·b ^ a·c.
- R7: If either operand is zero, the product is zero. This includes the all-zero inputs applied during reset.
- R8: For n ≥ 4, the top generator (only bit n/2 set) squared gives bit n/2+n/4 set together with bit 0. Multiplying 1 by the constant-generator stage yields the generator itself.
- R9: Subfield closure: if both operands have a zero high half, the product's high half is zero and its low half equals the half-width product of the low halves.
- R10: The product is combinational: it is valid for the operands of the same cycle, with no register stage, even when the operands change every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand, tower field element |
| b_i | input | WIDTH | Second operand, tower field element |
| p_o | output | WIDTH | Product a_i·b_i in the same tower field |

## Verification
Every product is due in the same cycle as its operands, because no register lies between the inputs and `p_o`. The driver applies a new operand pair on each falling clock edge and queues the expected value. The monitor compares on the following rising edge, half a period later, so at most one item sits in the queue at a time. Back-to-back operand changes in consecutive cycles show that no stale value from an earlier pair can pass a check.

// File: rtl/tower_mul_pkg.sv
package tower_mul_pkg;

  localparam int unsigned TOWER_MAX_WIDTH = 128;

  // legal element widths: powers of two from 1 up to the maximum
  function automatic bit tower_width_ok(int unsigned w);
    return (w >= 1) && (w <= TOWER_MAX_WIDTH) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/tower_mul_gen.sv
// Multiplies x_i by the element whose only set bit is W/2 (top generator
// of a W-bit tower element), using the relation X*X = X*X' + 1.
module tower_mul_gen #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] x_i,
  output logic [W-1:0] z_o
);

  localparam int unsigned H = W / 2;
  localparam logic [W-1:0] UNIT = W'(1);
  localparam logic [W-1:0] GEN  = UNIT << H;

  generate
    if (W == 2) begin : g_base
      // X0*(x0 + x1*X0) = x1 + X0*(x0 ^ x1)
      assign z_o = {x_i[0] ^ x_i[1], x_i[1]};
    end else begin : g_rec
      logic [H-1:0] hi_gen;
      tower_mul_gen #(.W(H)) u_sub (
        .x_i (x_i[W-1:H]),
        .z_o (hi_gen)
      );
      assign z_o = {x_i[H-1:0] ^ hi_gen, x_i[W-1:H]};
    end
  endgenerate

  always_comb begin : chk_gen
    if (x_i == UNIT)
      p_unit_gen_r8: assert (z_o == GEN)
        else $error("generator stage: 1 did not map to generator");
    if (x_i != '0)
      p_nonzero_r3: assert (z_o != '0)
        else $error("generator stage: nonzero input gave zero");
  end

endmodule

// File: rtl/tower_mul_core.sv
// Recursive Karatsuba tower multiplier core.
module tower_mul_core #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] z_o
);

  generate
    if (W == 1) begin : g_leaf
      assign z_o = x_i & y_i;
    end else begin : g_node
      localparam int unsigned H = W / 2;

      logic [H-1:0] x_lo, x_hi, y_lo, y_hi;
      logic [H-1:0] x_sum, y_sum;
      logic [H-1:0] prod_lo, prod_hi, prod_mid;

      assign x_lo  = x_i[H-1:0];
      assign x_hi  = x_i[W-1:H];
      assign y_lo  = y_i[H-1:0];
      assign y_hi  = y_i[W-1:H];
      assign x_sum = x_lo ^ x_hi;
      assign y_sum = y_lo ^ y_hi;

      tower_mul_core #(.W(H)) u_lo (
        .x_i (x_lo),
        .y_i (y_lo),
        .z_o (prod_lo)
      );

      tower_mul_core #(.W(H)) u_hi (
        .x_i (x_hi),
        .y_i (y_hi),
        .z_o (prod_hi)
      );

      tower_mul_core #(.W(H)) u_mid (
        .x_i (x_sum),
        .y_i (y_sum),
        .z_o (prod_mid)
      );

      if (W == 2) begin : g_pair
        assign z_o = {prod_mid ^ prod_lo, prod_lo ^ prod_hi};
      end else begin : g_wide
        logic [H-1:0] prod_hi_gen;
        tower_mul_gen #(.W(H)) u_gen (
          .x_i (prod_hi),
          .z_o (prod_hi_gen)
        );
        assign z_o = {prod_lo ^ prod_hi ^ prod_mid ^ prod_hi_gen,
                      prod_lo ^ prod_hi};
      end

      always_comb begin : chk_core
        if (x_hi == '0 && y_hi == '0)
          p_subfield_r9: assert (z_o[W-1:H] == '0)
            else $error("core: subfield product left its subfield");
      end
    end
  endgenerate

endmodule

// File: rtl/tower_mul.sv
module tower_mul #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] p_o
);

  localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);

  generate
    if (!tower_mul_pkg::tower_width_ok(WIDTH)) begin : g_bad_width
      $error("tower_mul: WIDTH must be a power of two from 1 to 128");
    end
  endgenerate

  tower_mul_core #(.W(WIDTH)) u_core (
    .x_i (a_i),
    .y_i (b_i),
    .z_o (p_o)
  );

  always_comb begin : chk_top
    if (a_i == UNIT)
      p_identity_a_r4: assert (p_o == b_i)
        else $error("top: 1*b differs from b");
    if (b_i == UNIT)
      p_identity_b_r4: assert (p_o == a_i)
        else $error("top: a*1 differs from a");
    if (a_i == '0 || b_i == '0)
      p_zero_r7: assert (p_o == '0)
        else $error("top: zero operand gave nonzero product");
  end

endmodule

// File: tb/tower_mul_test.sv
module tower_mul_test;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;   // 125 MHz

  logic [63:0] a_d, b_d;
  logic [63:0] p64;
  logic [15:0] p16;
  logic [7:0]  p8;
  logic [1:0]  p2;
  logic        p1;

  tower_mul #(.WIDTH(64)) uut     (.a_i(a_d),       .b_i(b_d),       .p_o(p64));
  tower_mul #(.WIDTH(16)) dut_w16 (.a_i(a_d[15:0]), .b_i(b_d[15:0]), .p_o(p16));
  tower_mul #(.WIDTH(8))  dut_w8  (.a_i(a_d[7:0]),  .b_i(b_d[7:0]),  .p_o(p8));
  tower_mul #(.WIDTH(2))  dut_w2  (.a_i(a_d[1:0]),  .b_i(b_d[1:0]),  .p_o(p2));
  tower_mul #(.WIDTH(1))  dut_w1  (.a_i(a_d[0]),    .b_i(b_d[0]),    .p_o(p1));

  typedef struct {
    int unsigned w;
    logic [63:0] exp;
    string       req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // ---------------- reference model (shift and reduce) ----------------
  function automatic logic [63:0] msk(int unsigned n);
    return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
  endfunction

  // multiply an m-bit block by its own top generator
  function automatic logic [63:0] top_gen(logic [63:0] x, int unsigned m);
    logic [63:0] xs [7];
    logic [63:0] r;
    int unsigned lv_n;
    lv_n = 0;
    for (int unsigned t = m; t > 1; t = t / 2) lv_n++;
    xs[0] = x & msk(m);
    for (int unsigned lv = 1; lv < lv_n; lv++)
      xs[lv] = xs[lv-1] >> ((m >> (lv - 1)) / 2);
    r = {62'd0, xs[lv_n-1][0] ^ xs[lv_n-1][1], xs[lv_n-1][1]};
    for (int lv = int'(lv_n) - 2; lv >= 0; lv--) begin
      int unsigned h;
      h = (m >> lv) / 2;
      r = (((xs[lv] & msk(h)) ^ r) << h) | (xs[lv] >> h);
    end
    return r;
  endfunction

  // multiply a w-bit element by generator level j (the element 1<<(2^j))
  function automatic logic [63:0] mul_gen(logic [63:0] a, int unsigned j, int unsigned w);
    logic [63:0] r;
    int unsigned m;
    m = 2 << j;
    r = '0;
    for (int unsigned k = 0; k < w / m; k++)
      r |= top_gen((a >> (k * m)) & msk(m), m) << (k * m);
    return r;
  endfunction

  function automatic logic [63:0] ref_mul(logic [63:0] a, logic [63:0] b, int unsigned w);
    logic [63:0] r, t;
    if (w == 1) return {63'd0, a[0] & b[0]};
    r = '0;
    for (int unsigned i = 0; i < w; i++) begin
      if (b[i]) begin
        t = a & msk(w);
        for (int unsigned j = 0; (1 << j) < w; j++)
          if (((i >> j) & 1) != 0) t = mul_gen(t, j, w);
        r ^= t;
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // ---------------- driver ----------------
  task automatic drive(int unsigned w, logic [63:0] a, logic [63:0] b,
                       logic [63:0] exp, string req);
    item_t it;
    @(negedge clk);
    a_d = a & msk(w);
    b_d = b & msk(w);
    it.w = w;
    it.exp = exp & msk(w);
    it.req = req;
    sb.push_back(it);
  endtask

  // ---------------- monitor ----------------
  always @(posedge clk) begin : monitor
    item_t it;
    logic [63:0] got;
    if (rst_n && sb.size() != 0) begin
      it = sb.pop_front();
      case (it.w)
        1:       got = {63'd0, p1};
        2:       got = {62'd0, p2};
        8:       got = {56'd0, p8};
        16:      got = {48'd0, p16};
        default: got = p64;
      endcase
      checks++;
      if (got !== it.exp) begin
        errors++;
        $display("FAIL %s width=%0d actual=%h expected=%h", it.req, it.w, got, it.exp);
      end
    end
  end

  // ---------------- stimulus ----------------
  initial begin : main
    int unsigned widths [3];
    logic [63:0] a, b, c;
    widths[0] = 8; widths[1] = 16; widths[2] = 64;
    rst_n = 1'b0;
    a_d = '0;
    b_d = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R7: state after reset, all-zero operands
    drive(64, 64'd0, 64'd0, 64'd0, "R7");

    // R1: width 1 exhaustive
    for (int i = 0; i < 4; i++)
      drive(1, 64'(i & 1), 64'(i >> 1), 64'((i & 1) & (i >> 1)), "R1");

    // R2: width 2 exhaustive, bit0 = a0b0^a1b1, bit1 = a0b1^a1b0^a1b1
    for (int i = 0; i < 4; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic a0, a1, b0, b1;
        a0 = i[0]; a1 = i[1]; b0 = k[0]; b1 = k[1];
        drive(2, 64'(i), 64'(k),
              {62'd0, (a0 & b1) ^ (a1 & b0) ^ (a1 & b1), (a0 & b0) ^ (a1 & b1)}, "R2");
      end
    end

    for (int wi = 0; wi < 3; wi++) begin
      int unsigned w;
      w = widths[wi];

      // R4: identity on both sides
      for (int n = 0; n < 4; n++) begin
        a = rnd64() & msk(w);
        drive(w, a, 64'd1, a, "R4");
        drive(w, 64'd1, a, a, "R4");
      end

      // R7: zero operand
      for (int n = 0; n < 3; n++) begin
        a = rnd64();
        drive(w, a, 64'd0, 64'd0, "R7");
        drive(w, 64'd0, a, 64'd0, "R7");
      end

      // R3: random products against the reference
      for (int n = 0; n < 30; n++) begin
        a = rnd64() & msk(w);
        b = rnd64() & msk(w);
        drive(w, a, b, ref_mul(a, b, w), "R3");
      end

      // R5: commutativity, operands swapped
      for (int n = 0; n < 10; n++) begin
        a = rnd64() & msk(w);
        b = rnd64() & msk(w);
        drive(w, b, a, ref_mul(a, b, w), "R5");
      end

      // R6: distributivity over XOR
      for (int n = 0; n < 10; n++) begin
        a = rnd64() & msk(w);
        b = rnd64() & msk(w);
        c = rnd64() & msk(w);
        drive(w, a, b ^ c, ref_mul(a, b, w) ^ ref_mul(a, c, w), "R6");
      end

      // R8: top generator squared
      a = 64'd1 << (w / 2);
      drive(w, a, a, (64'd1 << (w / 2 + w / 4)) | 64'd1, "R8");

      // R9: subfield closure
      for (int n = 0; n < 6; n++) begin
        a = rnd64() & msk(w / 2);
        b = rnd64() & msk(w / 2);
        drive(w, a, b, ref_mul(a, b, w / 2), "R9");
      end
    end

    // R10: operands change every cycle, each result due the same cycle
    for (int n = 0; n < 20; n++) begin
      a = (n % 2 == 0) ? rnd64() : ~a;
      b = rnd64();
      drive(64, a, b, ref_mul(a, b, 64), "R10");
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule